// File: doc/BRIEF.md
# SPI Target Serializer with Transmit Holding

This block is the target (slave) side of an SPI link. An external controller drives the serial clock, an active-low select and the MOSI line; the block samples MOSI, shifts out MISO and hands each completed word to a host on the system clock side. The host writes words to transmit, reads the last received word and reads a small status word. The frame length runs from 8 to 16 bits. The clock polarity and the sampling phase are configurable.

All three serial inputs pass through two-flop synchronizers into the system clock domain, and their edges are detected there. The system clock must run at least four times faster than the serial clock. The transmit side keeps only the newest host word. When the host has supplied nothing new since the last load, the block sends the word it last received again and raises an underrun flag.

Top module: `spi_tgt_link`

## Requirements
- R1: After reset `status` reads 4'b0010 (bit 1 transmit-empty set, all other flags clear), `rx_data` reads zero and `miso` is low.
- R2: MOSI is sampled MSB first on the rising serial clock edge when `cfg_cpol` XOR `cfg_ncpha` is 1, and on the falling edge otherwise. The first MISO bit is presented from the start of the frame, and each later bit follows the previous sample edge.
- R3: A frame is `cfg_bits` bits long, limited to the range 8 to 16. The received word is right-aligned in `rx_data` and its unused upper bits read as zero.
- R4: When the last bit of a frame is sampled, `rx_data` takes the new word and `status` bit 0 (receive-full) sets. A one-cycle `rd_rx` strobe clears bit 0. `rx_data` changes only when a frame completes.
- R5: A frame that completes while bit 0 is set and no `rd_rx` arrives in the same cycle sets `status` bit 2 (overrun), and the new word still replaces `rx_data`. Bit 2 clears only on a `rd_stat` strobe.
- R6: A host write made while nothing is pending and no frame is running goes straight into the shift register, and `status` bit 1 stays set.
- R7: Any other host write goes to the holding register and clears `status` bit 1. A later write replaces the earlier one. At the next frame start the newest held word moves into the shift register and bit 1 sets again.
- R8: If nothing has been written since the last load into the shift register, a frame start leaves the shift register as it is, so the last received word (all zeros after reset) is sent again, and `status` bit 3 (underrun) sets. A `rd_stat` strobe clears bit 3.
- R9: If `nss_n` rises before the last bit, the frame is dropped: no word is delivered and no receive flag changes. Serial clock edges while `nss_n` is high are ignored.
- R10: While `en` is low, no frame starts, serial clock edges are ignored and host writes are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Block enable |
| cfg_bits | input | 5 | Requested frame length in bits |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_ncpha | input | 1 | 1: sample on the leading edge, 0: sample on the trailing edge |
| wr_en | input | 1 | Host transmit write strobe |
| wr_data | input | 16 | Host transmit word |
| rd_rx | input | 1 | Host strobe that consumes the received word |
| rd_stat | input | 1 | Host strobe that reads the status and clears the error flags |
| rx_data | output | 16 | Last received word |
| status | output | 4 | {underrun, overrun, transmit-empty, receive-full} |
| sck | input | 1 | Serial clock from the controller |
| nss_n | input | 1 | Active-low target select |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out |

## Verification
A bit counter that is off by one shows within the same frame: `rx_data` would be shifted one place or the completion would never come, and the receive-full flag would not rise a few system clocks after the final sample edge. A wrong pending or fresh marker on the transmit side shows on MISO in the next frame as a stale or dropped host word, together with a wrong underrun bit. A flag that clears at the wrong time appears at the next status read. The bench keeps its own model of the shift and holding registers and predicts every MISO word and received word.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;

  typedef struct packed {
    logic udr;
    logic ovr;
    logic txe;
    logic rxf;
  } stat_t;

  // limit a requested frame length to the supported range
  function automatic int clamp_len(input int req, input int lo, input int hi);
    if (req < lo) return lo;
    if (req > hi) return hi;
    return req;
  endfunction

  // 1 when MOSI is sampled on the rising serial clock edge
  function automatic logic samp_on_rise(input logic cpol, input logic ncpha);
    return cpol ^ ncpha;
  endfunction

endpackage

// File: rtl/spi_tgt_sync.sv
module spi_tgt_sync #(
  parameter int N = 1,
  parameter logic [N-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= RST[i];
        s2 <= RST[i];
      end else begin
        s1 <= d[i];
        s2 <= s1;
      end
    end
    assign q[i] = s2;
  end
endmodule

// File: rtl/spi_tgt_rx.sv
module spi_tgt_rx #(
  parameter int MAXW = 16,
  parameter int CW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            nss_q,
  input  logic            frame_start,
  input  logic            samp_edge,
  input  logic            mosi_q,
  input  logic [CW-1:0]   len,
  output logic            active,
  output logic [CW-1:0]   cnt,
  output logic            frame_done,
  output logic [MAXW-1:0] rx_word
);
  logic [MAXW-1:0] sh;

  assign frame_done = active & samp_edge & (cnt == len - CW'(1));
  assign rx_word    = {sh[MAXW-2:0], mosi_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      sh     <= '0;
    end else if (!en || nss_q) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (frame_start) begin
      active <= 1'b1;
      cnt    <= '0;
      sh     <= '0;
    end else if (active && samp_edge) begin
      sh <= {sh[MAXW-2:0], mosi_q};
      if (frame_done) begin
        active <= 1'b0;
        cnt    <= '0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/spi_tgt_txhold.sv
module spi_tgt_txhold #(
  parameter int MAXW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            wr_en,
  input  logic [MAXW-1:0] wr_data,
  input  logic            active,
  input  logic            frame_start,
  input  logic            frame_done,
  input  logic [MAXW-1:0] rx_word,
  output logic [MAXW-1:0] sh_tx,
  output logic            tx_empty,
  output logic            underrun_evt
);
  logic [MAXW-1:0] hold;
  logic            hold_v;
  logic            fresh;   // shift register carries host data not yet sent
  logic            wr_ok;

  assign wr_ok        = en & wr_en;
  assign tx_empty     = ~hold_v;
  assign underrun_evt = frame_start & ~hold_v & ~fresh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_tx  <= '0;
      hold   <= '0;
      hold_v <= 1'b0;
      fresh  <= 1'b0;
    end else begin
      if (frame_start) begin
        if (hold_v) sh_tx <= hold;
        hold_v <= 1'b0;
        fresh  <= 1'b0;
      end else if (frame_done) begin
        sh_tx <= rx_word;
      end
      if (wr_ok) begin
        if (!fresh && !hold_v && !active && !frame_start) begin
          sh_tx <= wr_data;
          fresh <= 1'b1;
        end else begin
          hold   <= wr_data;
          hold_v <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_tgt_link.sv
module spi_tgt_link #(
  parameter int MAXW = 16,
  parameter int MINW = 8,
  localparam int CW = $clog2(MAXW + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [CW-1:0]   cfg_bits,
  input  logic            cfg_cpol,
  input  logic            cfg_ncpha,
  input  logic            wr_en,
  input  logic [MAXW-1:0] wr_data,
  input  logic            rd_rx,
  input  logic            rd_stat,
  output logic [MAXW-1:0] rx_data,
  output logic [3:0]      status,
  input  logic            sck,
  input  logic            nss_n,
  input  logic            mosi,
  output logic            miso
);
  import spi_tgt_pkg::*;

  logic            nss_q, sck_q, mosi_q, nss_d, sck_d;
  logic            sck_rise, sck_fall, samp_edge, frame_start;
  logic            active, frame_done, underrun_evt, tx_empty;
  logic [CW-1:0]   len, cnt, idx;
  logic [MAXW-1:0] rx_word, sh_tx, shv;
  stat_t           st;

  spi_tgt_sync #(.N(3), .RST(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({nss_n, sck, mosi}), .q({nss_q, sck_q, mosi_q})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nss_d <= 1'b1;
      sck_d <= 1'b0;
    end else begin
      nss_d <= nss_q;
      sck_d <= sck_q;
    end
  end

  assign sck_rise    = sck_q & ~sck_d;
  assign sck_fall    = ~sck_q & sck_d;
  assign samp_edge   = samp_on_rise(cfg_cpol, cfg_ncpha) ? sck_rise : sck_fall;
  assign frame_start = en & nss_d & ~nss_q;
  assign len         = CW'(clamp_len(int'(cfg_bits), MINW, MAXW));

  spi_tgt_rx #(.MAXW(MAXW), .CW(CW)) u_rx (
    .clk(clk), .rst_n(rst_n), .en(en), .nss_q(nss_q),
    .frame_start(frame_start), .samp_edge(samp_edge), .mosi_q(mosi_q),
    .len(len), .active(active), .cnt(cnt), .frame_done(frame_done),
    .rx_word(rx_word)
  );

  spi_tgt_txhold #(.MAXW(MAXW)) u_tx (
    .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en), .wr_data(wr_data),
    .active(active), .frame_start(frame_start), .frame_done(frame_done),
    .rx_word(rx_word), .sh_tx(sh_tx), .tx_empty(tx_empty),
    .underrun_evt(underrun_evt)
  );

  assign idx  = len - CW'(1) - cnt;
  assign shv  = sh_tx >> idx;
  assign miso = active & shv[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data <= '0;
      st.rxf  <= 1'b0;
      st.ovr  <= 1'b0;
      st.udr  <= 1'b0;
    end else begin
      if (frame_done) begin
        rx_data <= rx_word;
        st.rxf  <= 1'b1;
      end else if (rd_rx) begin
        st.rxf <= 1'b0;
      end
      if (frame_done && st.rxf && !rd_rx) st.ovr <= 1'b1;
      else if (rd_stat)                   st.ovr <= 1'b0;
      if (underrun_evt)   st.udr <= 1'b1;
      else if (rd_stat)   st.udr <= 1'b0;
    end
  end

  assign st.txe = tx_empty;
  assign status = st;
endmodule

// File: rtl/spi_tgt_link_chk.sv
module spi_tgt_link_chk #(
  parameter int MAXW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            en,
  input logic            wr_en,
  input logic            rd_rx,
  input logic            rd_stat,
  input logic [3:0]      status,
  input logic [MAXW-1:0] rx_data,
  input logic            frame_start,
  input logic            frame_done,
  input logic            underrun_evt,
  input logic            active
);
  AST_DONE_SETS_FULL: assert property (@(posedge clk) disable iff (!rst_n) frame_done |=> status[0]); // R4
  AST_READ_CLEARS_FULL: assert property (@(posedge clk) disable iff (!rst_n) rd_rx && !frame_done |=> !status[0]); // R4
  AST_RXDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !frame_done |=> $stable(rx_data)); // R4
  AST_OVR_ON_UNREAD: assert property (@(posedge clk) disable iff (!rst_n) frame_done && status[0] && !rd_rx |=> status[2]); // R5
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) status[2] && !rd_stat |=> status[2]); // R5
  AST_TXE_AT_START: assert property (@(posedge clk) disable iff (!rst_n) frame_start && !wr_en |=> status[1]); // R7
  AST_UDR_SET: assert property (@(posedge clk) disable iff (!rst_n) underrun_evt |=> status[3]); // R8
  AST_UDR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) rd_stat && !underrun_evt |=> !status[3]); // R8
  AST_IDLE_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n) !active |-> !frame_done); // R9
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !en |-> !frame_done && !frame_start); // R10
endmodule

bind spi_tgt_link spi_tgt_link_chk #(.MAXW(MAXW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en), .rd_rx(rd_rx),
  .rd_stat(rd_stat), .status(status), .rx_data(rx_data),
  .frame_start(frame_start), .frame_done(frame_done),
  .underrun_evt(underrun_evt), .active(active)
);

// File: tb/sim_spi_tgt_link.sv
`timescale 1ns/1ps
module sim_spi_tgt_link;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b1;
  logic [4:0] cfg_bits = 5'd8;
  logic cfg_cpol = 1'b0, cfg_ncpha = 1'b1;
  logic wr_en = 1'b0, rd_rx = 1'b0, rd_stat = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rx_data;
  logic [3:0] status;
  logic sck = 1'b0, nss_n = 1'b1, mosi = 1'b0, miso;

  always #2.5 clk = ~clk;

  spi_tgt_link u0 (.*);

  localparam int HP = 8;   // serial half period in system clocks

  int n_chk = 0, n_bad = 0;
  bit done_flag = 0;

  typedef struct { logic [15:0] mi; logic [15:0] rx; string tag; } exp_t;
  exp_t q[$];
  event ev_frame;
  logic [15:0] cap_miso;

  // bench model of the transmit side
  logic [15:0] m_sh = '0, m_hold = '0;
  bit m_fresh = 0, m_hv = 0, m_udr = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int eff_len(input int c);
    return (c < 8) ? 8 : ((c > 16) ? 16 : c);
  endfunction

  function automatic logic [15:0] lowbits(input logic [15:0] v, input int n);
    return v & ((17'h1 << n) - 17'h1);
  endfunction

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_wr(input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
    if (en) begin
      if (!m_fresh && !m_hv) begin m_sh = d; m_fresh = 1; end
      else begin m_hold = d; m_hv = 1; end
    end
    ticks(2);
  endtask

  task automatic pulse_rx();
    @(negedge clk); rd_rx = 1'b1; @(negedge clk); rd_rx = 1'b0; ticks(2);
  endtask

  task automatic pulse_stat();
    @(negedge clk); rd_stat = 1'b1; @(negedge clk); rd_stat = 1'b0; ticks(2);
  endtask

  // kind 0: full frame, 1: aborted after 3 bits, 2: frame while disabled
  task automatic frame(input int cfg, input bit cp, input bit nc,
                       input logic [15:0] mw, input int kind, input string tag);
    int n, nd;
    exp_t e;
    n = eff_len(cfg);
    nd = (kind == 1) ? 3 : n;
    @(negedge clk); cfg_bits = 5'(cfg); cfg_cpol = cp; cfg_ncpha = nc; sck = cp;
    ticks(HP);
    if (kind != 2) begin
      m_udr = 0;
      if (m_hv) begin m_sh = m_hold; m_hv = 0; end
      else if (!m_fresh) m_udr = 1;
      m_fresh = 0;
    end
    e.mi = lowbits(m_sh, n); e.rx = lowbits(mw, n); e.tag = tag;
    if (kind == 0) q.push_back(e);
    cap_miso = '0;
    nss_n = 1'b0; mosi = mw[n-1];
    ticks(HP);
    for (int i = 0; i < nd; i++) begin
      if (nc) begin
        mosi = mw[n-1-i];
        ticks(HP);
        cap_miso = {cap_miso[14:0], miso}; sck = ~cp;
        ticks(HP);
        sck = cp;
      end else begin
        ticks(HP);
        sck = ~cp; mosi = mw[n-1-i];
        ticks(HP);
        cap_miso = {cap_miso[14:0], miso}; sck = cp;
      end
    end
    ticks(HP / 2);
    nss_n = 1'b1;
    ticks(HP);
    if (kind == 0) begin
      m_sh = lowbits(mw, n);
      -> ev_frame;
      ticks(1);
    end
  endtask

  // scoreboard monitor: compares each completed frame with its expectation
  initial begin
    forever begin
      @(ev_frame);
      if (q.size() == 0) chk("R2", "unexpected frame", 1, 0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk("R2", {e.tag, " miso word"}, int'(cap_miso), int'(e.mi));
        chk("R3", {e.tag, " rx_data"}, int'(rx_data), int'(e.rx));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    ticks(4);
    rst_n = 1'b1;
    ticks(4);
    // R1 reset state
    chk("R1", "status after reset", int'(status), 4'b0010);
    chk("R1", "rx_data after reset", int'(rx_data), 0);
    chk("R1", "miso after reset", int'(miso), 0);

    // R8 first frame after reset sends zeros with underrun; R2 mode cpol0/ncpha1
    frame(8, 0, 1, 16'h00A5, 0, "R2 R8 first");
    chk("R4", "status after first frame", int'(status), 4'b1011);
    chk("R8", "underrun model", int'(status[3]), int'(m_udr));
    pulse_stat();
    chk("R8", "underrun cleared by status read", int'(status[3]), 0);
    pulse_rx();
    chk("R4", "rx_full cleared by read", int'(status[0]), 0);

    // R6 direct write, mode cpol1/ncpha0
    host_wr(16'h003C);
    chk("R6", "tx_empty after direct write", int'(status[1]), 1);
    frame(8, 1, 0, 16'h005A, 0, "R6 direct");
    chk("R6", "no underrun with fresh data", int'(status[3]), 0);
    chk("R4", "rx_full set", int'(status[0]), 1);

    // R7 holding register keeps newest write; R5 overrun
    host_wr(16'h0011);
    host_wr(16'h0022);
    chk("R7", "tx_empty cleared by held write", int'(status[1]), 0);
    host_wr(16'h0033);
    frame(8, 1, 1, 16'h00C6, 0, "R7 newest held");
    chk("R7", "tx_empty after frame start", int'(status[1]), 1);
    chk("R5", "overrun set", int'(status[2]), 1);
    pulse_rx();
    chk("R5", "overrun survives data read", int'(status[2]), 1);
    pulse_stat();
    chk("R5", "overrun cleared by status read", int'(status[2]), 0);

    // R8 retransmit of last received word
    frame(8, 0, 0, 16'h0081, 0, "R8 retransmit");
    chk("R8", "underrun on retransmit", int'(status[3]), 1);
    pulse_stat(); pulse_rx();

    // R3 16-bit and 12-bit frames, clamping below 8
    host_wr(16'hBEEF);
    frame(16, 1, 1, 16'h1234, 0, "R3 sixteen");
    pulse_rx();
    host_wr(16'h0ABC);
    frame(12, 0, 0, 16'hF5A5, 0, "R3 twelve");
    chk("R3", "upper bits zero", int'(rx_data[15:12]), 0);
    pulse_rx();
    frame(3, 0, 1, 16'h00C3, 0, "R3 clamp low");
    frame(20, 1, 0, 16'h8001, 0, "R3 clamp high");
    pulse_stat(); pulse_rx();

    // R9 aborted frame delivers nothing
    frame(8, 0, 1, 16'h00FF, 1, "R9 abort");
    chk("R9", "rx_full after abort", int'(status[0]), 0);
    chk("R9", "rx_data unchanged after abort", int'(rx_data), 16'h8001);
    pulse_stat();

    // R10 disabled: writes dropped, frames ignored
    en = 1'b0;
    host_wr(16'h0077);
    host_wr(16'h0066);
    chk("R10", "tx_empty with writes while disabled", int'(status[1]), 1);
    frame(8, 0, 1, 16'h0042, 2, "R10 disabled");
    chk("R10", "no receive while disabled", int'(status[0]), 0);
    chk("R10", "rx_data kept while disabled", int'(rx_data), 16'h8001);
    en = 1'b1;
    ticks(4);
    frame(8, 0, 1, 16'h0024, 0, "R10 re-enabled");
    chk("R8", "underrun after dropped writes", int'(status[3]), 1);

    ticks(10);
    chk("R2", "all expectations consumed", q.size(), 0);
    done_flag = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule